// File: doc/BRIEF.md
# Hot-Plug and Power-Management Event Status Register

This block is the 32-bit event status register of a PCI Express root port. It watches four upstream flags: slot command completed, attention button pressed, presence detect changed, and root power-management status. A 0-to-1 change on any of them, seen while its mode enable is set, sets a sticky status bit. Those bits together drive one SMI request line.

Two more sticky bits record that a hot-plug interrupt or a power-management interrupt was needed and was routed to SCI. These two bits drive an SCI request line.

Software reads the register through combinational read data. It clears any event bit by writing 1 to it in a single-cycle write strobe. Writing 0 leaves a bit alone. The reserved bits always read 0.

Top module: `hp_evt_status`

## Requirements
- R1: After reset, and while reset is held, `rd_data` is 0x0000_0000 and both `smi_req` and `sci_req` are 0.
- R2: Bit 3 sets on a 0-to-1 change of `cmd_done_flag` sampled while `hp_smi_en` is 1.
- R3: Bit 2 sets on a 0-to-1 change of `attn_btn_flag` sampled while `hp_smi_en` is 1.
- R4: Bit 1 sets on a 0-to-1 change of `pres_chg_flag` sampled while `hp_smi_en` is 1.
- R5: Bit 0 sets on a 0-to-1 change of `pm_stat_flag` sampled while `pm_smi_en` is 1.
- R6: A flag rising while its enable is 0 sets nothing, and nothing is set later either. This holds if the enable rises afterwards or the flag stays high. A flag held high never sets a bit again after the bit is cleared.
- R7: A cycle with `wr_en` = 1 clears each of bits 31, 30 and 3:0 whose `wr_data` bit is 1. Bits whose `wr_data` bit is 0 keep their value.
- R8: When a hardware set and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R9: Bits 29:4 of `rd_data` always read 0, whatever is written.
- R10: `smi_req` is 1 exactly when any of bits 3:0 is set.
- R11: Bit 30 sets in any cycle where `hp_sci_evt` is 1, and bit 31 sets in any cycle where `pm_sci_evt` is 1. `sci_req` is 1 exactly when bit 31 or bit 30 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done_flag | input | 1 | Slot command-completed flag |
| attn_btn_flag | input | 1 | Attention-button-pressed flag |
| pres_chg_flag | input | 1 | Presence-detect-changed flag |
| pm_stat_flag | input | 1 | Root power-management status flag |
| hp_smi_en | input | 1 | Hot-plug SMI mode enable |
| pm_smi_en | input | 1 | Power-management SMI mode enable |
| hp_sci_evt | input | 1 | Hot-plug interrupt needed and routed to SCI |
| pm_sci_evt | input | 1 | Power-management interrupt needed and routed to SCI |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, 1 clears the bit |
| rd_data | output | 32 | Current register value |
| smi_req | output | 1 | SMI request |
| sci_req | output | 1 | SCI request |

## Verification
A flag change, an enable, an SCI event and a write strobe all act on the one clock edge that samples them. A new register value therefore appears on `rd_data`, `smi_req` and `sci_req` one edge after the stimulus is driven. There is no additional pipeline stage. The bench drives every input at a falling edge and lets one rising edge pass. It compares all three outputs at the next falling edge, and only then drives the next stimulus. Suppression and no-effect cases are judged from the read value in that same cycle.

// File: rtl/hp_evt_pkg.sv
package hp_evt_pkg;
    localparam int REG_W      = 32;
    localparam int NUM_SMI    = 4;
    localparam int NUM_SCI    = 2;
    localparam int SCI_LO_BIT = 30;   // bit 30 hot-plug SCI, bit 31 power-management SCI
    localparam int PM_IDX     = 0;    // SMI bit driven by the power-management enable

    typedef struct packed {
        logic set;
        logic clr;
    } cell_ctl_t;
endpackage

// File: rtl/hp_rise_det.sv
module hp_rise_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = lvl_i;
        rise_o = lvl_i & ~prev_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/hp_w1c_cell.sv
module hp_w1c_cell
    import hp_evt_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  cell_ctl_t ctl_i,
    output logic      q_o
);
    logic q_d, q_q;

    always_comb begin
        q_d = q_q;
        if (ctl_i.clr) q_d = 1'b0;
        if (ctl_i.set) q_d = 1'b1;   // set has priority over clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
    end

    assign q_o = q_q;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.set |=> q_o);
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.clr && !ctl_i.set) |=> !q_o);
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_i.clr && !ctl_i.set) |=> $stable(q_o));
endmodule

// File: rtl/hp_evt_status.sv
module hp_evt_status
    import hp_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_done_flag,
    input  logic             attn_btn_flag,
    input  logic             pres_chg_flag,
    input  logic             pm_stat_flag,
    input  logic             hp_smi_en,
    input  logic             pm_smi_en,
    input  logic             hp_sci_evt,
    input  logic             pm_sci_evt,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             smi_req,
    output logic             sci_req
);
    logic [NUM_SMI-1:0] flags, rise, smi_en, smi_q;
    logic [NUM_SCI-1:0] sci_evt, sci_q;
    cell_ctl_t          smi_ctl [NUM_SMI];
    cell_ctl_t          sci_ctl [NUM_SCI];

    assign flags   = {cmd_done_flag, attn_btn_flag, pres_chg_flag, pm_stat_flag};
    assign sci_evt = {pm_sci_evt, hp_sci_evt};

    hp_rise_det #(.W(NUM_SMI)) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (flags),
        .rise_o (rise)
    );

    always_comb begin
        for (int i = 0; i < NUM_SMI; i++) begin
            smi_en[i]      = (i == PM_IDX) ? pm_smi_en : hp_smi_en;
            smi_ctl[i].set = rise[i] & smi_en[i];
            smi_ctl[i].clr = wr_en & wr_data[i];
        end
        for (int j = 0; j < NUM_SCI; j++) begin
            sci_ctl[j].set = sci_evt[j];
            sci_ctl[j].clr = wr_en & wr_data[SCI_LO_BIT + j];
        end
    end

    for (genvar g = 0; g < NUM_SMI; g++) begin : g_smi
        hp_w1c_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_i (smi_ctl[g]),
            .q_o   (smi_q[g])
        );
    end

    for (genvar g = 0; g < NUM_SCI; g++) begin : g_sci
        hp_w1c_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl_i (sci_ctl[g]),
            .q_o   (sci_q[g])
        );
    end

    always_comb begin
        rd_data                                  = '0;
        rd_data[NUM_SMI-1:0]                     = smi_q;
        rd_data[SCI_LO_BIT+NUM_SCI-1:SCI_LO_BIT] = sci_q;
        smi_req                                  = |smi_q;
        sci_req                                  = |sci_q;
    end

    a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[SCI_LO_BIT-1:NUM_SMI] == '0);
    a_r10_smi_or: assert property (@(posedge clk) disable iff (!rst_n)
        smi_req == (rd_data[NUM_SMI-1:0] != '0));
    a_r11_sci_or: assert property (@(posedge clk) disable iff (!rst_n)
        sci_req == (rd_data[REG_W-1:SCI_LO_BIT] != '0));
    a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[3]) |-> ($past(hp_smi_en) && $past(cmd_done_flag)));
    a_r5_gate: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[0]) |-> ($past(pm_smi_en) && $past(pm_stat_flag)));
    a_r1_reset: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
endmodule

// File: tb/tb_hp_evt_status.sv
module tb_hp_evt_status;
    typedef struct packed {
        logic [3:0]  flg;     // {cmd, attn, pres, pm}
        logic        hp_en;
        logic        pm_en;
        logic        hp_sci;
        logic        pm_sci;
        logic        wr;
        logic [31:0] wd;
        logic [31:0] exp_rd;
        logic        exp_smi;
        logic        exp_sci;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VEC [NV] = '{
        '{4'b0000,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd1 },  // R1 idle
        '{4'b1000,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h8,        1'b1,1'b0,4'd2 },  // R2
        '{4'b1000,1'b1,1'b0,1'b0,1'b0,1'b1,32'h8,        32'h0,        1'b0,1'b0,4'd6 },  // R6 held level, R7 clear
        '{4'b0000,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },
        '{4'b0100,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h4,        1'b1,1'b0,4'd3 },  // R3
        '{4'b0110,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h6,        1'b1,1'b0,4'd4 },  // R4
        '{4'b0110,1'b1,1'b0,1'b0,1'b0,1'b1,32'h2,        32'h4,        1'b1,1'b0,4'd7 },  // R7 selective
        '{4'b0000,1'b1,1'b0,1'b0,1'b0,1'b1,32'h0,        32'h4,        1'b1,1'b0,4'd7 },  // R7 write 0
        '{4'b0000,1'b1,1'b0,1'b0,1'b0,1'b1,32'hFFFFFFFF, 32'h0,        1'b0,1'b0,4'd9 },  // R9 reserved
        '{4'b0001,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,        32'h1,        1'b1,1'b0,4'd5 },  // R5, R10
        '{4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,32'h1,        32'h0,        1'b0,1'b0,4'd10},  // R10
        '{4'b0001,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },  // R6 gated
        '{4'b0001,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },  // R6 late enable
        '{4'b0000,1'b0,1'b1,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },
        '{4'b1110,1'b0,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },  // R6 hp gated
        '{4'b0000,1'b1,1'b0,1'b0,1'b0,1'b0,32'h0,        32'h0,        1'b0,1'b0,4'd6 },
        '{4'b0000,1'b0,1'b0,1'b1,1'b0,1'b0,32'h0,        32'h40000000, 1'b0,1'b1,4'd11},  // R11 hp sci
        '{4'b0000,1'b0,1'b0,1'b0,1'b1,1'b0,32'h0,        32'hC0000000, 1'b0,1'b1,4'd11},  // R11 pm sci
        '{4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,32'h40000000, 32'h80000000, 1'b0,1'b1,4'd7 },  // R7 bit 30
        '{4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,32'h80000000, 32'h0,        1'b0,1'b0,4'd11},  // R11 sci drops
        '{4'b1000,1'b1,1'b0,1'b0,1'b0,1'b1,32'h8,        32'h8,        1'b1,1'b0,4'd8 },  // R8 smi bit
        '{4'b1000,1'b0,1'b0,1'b0,1'b0,1'b1,32'hFFFFFFFF, 32'h0,        1'b0,1'b0,4'd7 },
        '{4'b0000,1'b0,1'b0,1'b0,1'b1,1'b1,32'h80000000, 32'h80000000, 1'b0,1'b1,4'd8 },  // R8 sci bit
        '{4'b0000,1'b0,1'b0,1'b0,1'b0,1'b1,32'h80000000, 32'h0,        1'b0,1'b0,4'd7 }
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_done_flag, attn_btn_flag, pres_chg_flag, pm_stat_flag;
    logic        hp_smi_en, pm_smi_en, hp_sci_evt, pm_sci_evt, wr_en;
    logic [31:0] wr_data, rd_data;
    logic        smi_req, sci_req;
    int          total = 0;
    int          bad   = 0;
    bit          done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    hp_evt_status dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_done_flag(cmd_done_flag), .attn_btn_flag(attn_btn_flag),
        .pres_chg_flag(pres_chg_flag), .pm_stat_flag(pm_stat_flag),
        .hp_smi_en(hp_smi_en), .pm_smi_en(pm_smi_en),
        .hp_sci_evt(hp_sci_evt), .pm_sci_evt(pm_sci_evt),
        .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .smi_req(smi_req), .sci_req(sci_req)
    );

    task automatic check32(input int rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        {cmd_done_flag, attn_btn_flag, pres_chg_flag, pm_stat_flag} = v.flg;
        hp_smi_en  = v.hp_en;
        pm_smi_en  = v.pm_en;
        hp_sci_evt = v.hp_sci;
        pm_sci_evt = v.pm_sci;
        wr_en      = v.wr;
        wr_data    = v.wd;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        drive('0);
        repeat (3) step();
        // R1: reset state
        check32(1, "rd_data in reset", rd_data, 32'h0);
        check32(1, "smi/sci in reset", {30'h0, smi_req, sci_req}, 32'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            step();
            check32(VEC[i].req, $sformatf("vec %0d rd_data", i), rd_data, VEC[i].exp_rd);
            check32(VEC[i].req, $sformatf("vec %0d smi_req", i), {31'h0, smi_req}, {31'h0, VEC[i].exp_smi});
            check32(VEC[i].req, $sformatf("vec %0d sci_req", i), {31'h0, sci_req}, {31'h0, VEC[i].exp_sci});
        end

        // R2 R3 R4 R5: all four edges at once
        drive('0);
        step();
        {cmd_done_flag, attn_btn_flag, pres_chg_flag, pm_stat_flag} = 4'b1111;
        hp_smi_en = 1'b1;
        pm_smi_en = 1'b1;
        step();
        check32(2, "all four edges", rd_data, 32'h0000000F);

        // R9: reserved bits stay 0 under a full write that leaves nothing else set
        drive('0);
        wr_en   = 1'b1;
        wr_data = 32'h3FFFFFF0;
        step();
        check32(9, "reserved write", rd_data, 32'h0000000F);

        // R1: reset clears a populated register
        drive('0);
        hp_sci_evt = 1'b1;
        step();
        check32(11, "sci before reset", rd_data, 32'h4000000F);
        rst_n = 1'b0;
        drive('0);
        step();
        check32(1, "reset clears", {rd_data[31:2], smi_req, sci_req}, 32'h0);
        rst_n = 1'b1;
        step();
        check32(1, "after reset release", rd_data, 32'h0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule